// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a translation miss by reading a two-level page table that sits in untranslated physical memory. A requester presents a 32-bit virtual address, the kind of access it wants to perform, and the physical base address of the current process's top-level table. The walker then issues up to two single-word reads over a simple valid/ready request port with a separate response strobe. The first read fetches the top-level entry, and the second fetches the leaf entry from the table that the first entry names.

When the walk finishes, the walker raises a one-cycle completion strobe. On success, the strobe carries the leaf entry so the translation cache can be refilled from it. If a non-valid entry turns up at either level, the strobe instead carries a page-fault flag together with the level at which the walk stopped. A permission verdict for the requested access is computed from the leaf entry's rights bits and is reported in the same cycle as the result.

The virtual address is always split the same way: ten bits select the top-level entry, ten bits select the leaf entry, and twelve bits are the page offset, which plays no part in the walk. Each entry is four bytes wide. Only one walk is in progress at a time.

Top module: `pt_walker`

## Requirements
- R1: After a synchronous active-low reset, `walk_ready` is 1 and both `rd_valid` and `res_valid` are 0.
- R2: The first read of a walk goes to address `root + va[31:22]*4`. Here `root` and `va` are the values sampled in the cycle when the request is accepted, so later changes on `walk_root` do not affect that walk.
- R3: When the top-level entry is valid, the second read goes to address `{entry[31:12], 12'h000} + va[21:12]*4`. Bits 11:0 of the virtual address never influence either read address.
- R4: Entry layout: bit 0 is valid, bit 1 allows loads, bit 2 allows stores, bit 3 allows fetches, and bits 31:12 are the physical page number. If the top-level entry has bit 0 clear, the walk ends with `res_fault`=1 and `res_level`=0, no second read is issued, and `res_pte` carries that entry.
- R5: If the leaf entry has bit 0 clear, the walk ends with `res_fault`=1, `res_level`=1, and `res_pte` equal to the leaf entry.
- R6: A successful walk raises `res_valid` for exactly one cycle, with `res_fault`=0, `res_level`=1 and `res_pte` equal to the leaf entry.
- R7: Access codes are 0 for load, 1 for store, 2 for fetch, and 3 for reserved. On success, `res_deny` is 1 when the leaf entry lacks the rights bit that the access needs, and it is always 1 for code 3. `res_deny` is 0 whenever `res_fault` is 1.
- R8: `walk_ready` is 1 only while no walk is in progress. A request raised while it is 0 starts no walk and adds no read.
- R9: While `rd_valid` is 1 and `rd_ready` is 0, `rd_valid` stays 1 and `rd_addr` stays unchanged. A walk issues at most one outstanding read, and it waits for `rsp_valid` whatever the memory latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| walk_valid | input | 1 | Walk request strobe |
| walk_ready | output | 1 | High when a new walk can be accepted |
| walk_va | input | 32 | Virtual address that missed |
| walk_acc | input | 2 | Access kind: 0 load, 1 store, 2 fetch, 3 reserved |
| walk_root | input | 32 | Physical base of the top-level table |
| rd_valid | output | 1 | Memory read request valid |
| rd_ready | input | 1 | Memory accepts the read request |
| rd_addr | output | 32 | Physical word address of the read |
| rsp_valid | input | 1 | Read data valid |
| rsp_data | input | 32 | Read data (a table entry) |
| res_valid | output | 1 | One-cycle result strobe |
| res_fault | output | 1 | Walk ended on a non-valid entry |
| res_level | output | 1 | Level of the last entry read (0 top, 1 leaf) |
| res_pte | output | 32 | Last entry read |
| res_deny | output | 1 | Leaf rights do not allow the requested access |

## Verification
If the walker's state is wrong, the effect reaches the ports within a few cycles. A wrong index or base latch shows up as a wrong `rd_addr` on the very first or second read. A state that skips or repeats a level shows up as the wrong number of reads before `res_valid`. A state that fails to return to idle keeps `walk_ready` low, and the next walk then times out. Variable response latency and request stalls check that the walker neither moves on before data arrives nor changes an address that is still waiting to be accepted.

// File: rtl/ptw_pkg.sv
// Package: shared types and entry-field positions for the page table walker.
// Assumes 4-byte entries with valid and rights bits in the low nibble.
package ptw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_L1_REQ,
        ST_L1_WAIT,
        ST_L2_REQ,
        ST_L2_WAIT,
        ST_DONE,
        ST_FAULT
    } walk_state_t;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_t;

    localparam int PTE_VALID_BIT = 0;
    localparam int PTE_RD_BIT    = 1;
    localparam int PTE_WR_BIT    = 2;
    localparam int PTE_EX_BIT    = 3;
    localparam int N_RIGHTS      = 3;
endpackage

// File: rtl/ptw_entry_addr.sv
// Module: forms the physical address of a table entry as base + index * entry size.
// Assumes the entry size is a power of two given as a log2 shift.
module ptw_entry_addr #(
    parameter int PA_W       = 32,
    parameter int IDX_W      = 10,
    parameter int ENTRY_LOG2 = 2
) (
    input  logic [PA_W-1:0]  base,
    input  logic [IDX_W-1:0] index,
    output logic [PA_W-1:0]  entry_addr
);
    localparam int PAD_W = PA_W - IDX_W - ENTRY_LOG2;

    logic [PA_W-1:0] byte_off;

    // Scale the index to a byte offset and add it to the base.
    always_comb begin
        byte_off   = {{PAD_W{1'b0}}, index, {ENTRY_LOG2{1'b0}}};
        entry_addr = base + byte_off;
    end
endmodule

// File: rtl/ptw_perm_check.sv
// Module: decides whether a leaf entry's rights bits allow the requested access.
// Assumes rights are given as {fetch, store, load}; the reserved access kind is always refused.
module ptw_perm_check
    import ptw_pkg::*;
#(
    parameter int NR = N_RIGHTS
) (
    input  logic [NR-1:0] rights,
    input  logic [1:0]    acc,
    output logic          deny
);
    logic [NR-1:0] need;

    // One-hot "right needed" vector, one lane per access kind.
    for (genvar k = 0; k < NR; k++) begin : g_need
        assign need[k] = (acc == 2'(k));
    end

    // Refuse when the needed right is missing or the kind is reserved.
    always_comb begin
        deny = ((need & rights) == '0);
    end
endmodule

// File: rtl/pt_walker.sv
// Module: two-level page table walker. Accepts one walk at a time, reads the
// top-level entry and then the leaf entry over a valid/ready read port, and
// reports the leaf entry or a page fault as a one-cycle result.
// Assumes tables sit in untranslated physical memory and responses arrive in order.
module pt_walker
    import ptw_pkg::*;
#(
    parameter int PA_W  = 32,
    parameter int IDX_W = 10,
    parameter int OFF_W = 12,
    parameter int PTE_W = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       walk_valid,
    output logic                       walk_ready,
    input  logic [2*IDX_W+OFF_W-1:0]   walk_va,
    input  logic [1:0]                 walk_acc,
    input  logic [PA_W-1:0]            walk_root,
    output logic                       rd_valid,
    input  logic                       rd_ready,
    output logic [PA_W-1:0]            rd_addr,
    input  logic                       rsp_valid,
    input  logic [PTE_W-1:0]           rsp_data,
    output logic                       res_valid,
    output logic                       res_fault,
    output logic                       res_level,
    output logic [PTE_W-1:0]           res_pte,
    output logic                       res_deny
);
    localparam int VA_W  = 2*IDX_W + OFF_W;
    localparam int PPN_W = PTE_W - OFF_W;

    walk_state_t            state_q, state_d;
    logic [2*IDX_W-1:0]     vpn_q;
    logic [1:0]             acc_q;
    logic [PA_W-1:0]        root_q;
    logic [PA_W-1:0]        leaf_base_q;
    logic [PTE_W-1:0]       pte_q;
    logic                   lvl_q;

    logic [PA_W-1:0]        sel_base;
    logic [IDX_W-1:0]       sel_idx;
    logic                   perm_deny;
    logic                   accept;
    logic                   rsp_ok;

    // Request handshake and validity of the returning entry.
    always_comb begin
        accept = walk_valid && (state_q == ST_IDLE);
        rsp_ok = rsp_data[PTE_VALID_BIT];
    end

    // Next-state logic of the walk sequencer.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:    if (walk_valid) state_d = ST_L1_REQ;
            ST_L1_REQ:  if (rd_ready)   state_d = ST_L1_WAIT;
            ST_L1_WAIT: if (rsp_valid)  state_d = rsp_ok ? ST_L2_REQ : ST_FAULT;
            ST_L2_REQ:  if (rd_ready)   state_d = ST_L2_WAIT;
            ST_L2_WAIT: if (rsp_valid)  state_d = rsp_ok ? ST_DONE : ST_FAULT;
            default:                    state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Capture of the request fields at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vpn_q  <= '0;
            acc_q  <= '0;
            root_q <= '0;
        end else if (accept) begin
            vpn_q  <= walk_va[VA_W-1:OFF_W];
            acc_q  <= walk_acc;
            root_q <= walk_root;
        end
    end

    // Capture of returned entries and the leaf table base.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            leaf_base_q <= '0;
            pte_q       <= '0;
            lvl_q       <= 1'b0;
        end else if (rsp_valid && (state_q == ST_L1_WAIT)) begin
            leaf_base_q <= PA_W'({rsp_data[PTE_W-1:OFF_W], {OFF_W{1'b0}}});
            pte_q       <= rsp_data;
            lvl_q       <= 1'b0;
        end else if (rsp_valid && (state_q == ST_L2_WAIT)) begin
            pte_q       <= rsp_data;
            lvl_q       <= 1'b1;
        end
    end

    // Pick the base and index for the level being read.
    always_comb begin
        if (state_q == ST_L2_REQ) begin
            sel_base = leaf_base_q;
            sel_idx  = vpn_q[IDX_W-1:0];
        end else begin
            sel_base = root_q;
            sel_idx  = vpn_q[2*IDX_W-1:IDX_W];
        end
    end

    ptw_entry_addr #(
        .PA_W       (PA_W),
        .IDX_W      (IDX_W),
        .ENTRY_LOG2 (2)
    ) u_addr (
        .base       (sel_base),
        .index      (sel_idx),
        .entry_addr (rd_addr)
    );

    ptw_perm_check #(
        .NR     (N_RIGHTS)
    ) u_perm (
        .rights (pte_q[PTE_EX_BIT:PTE_RD_BIT]),
        .acc    (acc_q),
        .deny   (perm_deny)
    );

    // Port outputs decoded from the state.
    always_comb begin
        walk_ready = (state_q == ST_IDLE);
        rd_valid   = (state_q == ST_L1_REQ) || (state_q == ST_L2_REQ);
        res_valid  = (state_q == ST_DONE) || (state_q == ST_FAULT);
        res_fault  = (state_q == ST_FAULT);
        res_level  = lvl_q;
        res_pte    = pte_q;
        res_deny   = (state_q == ST_DONE) && perm_deny;
    end

    logic unused_ppn_w;
    assign unused_ppn_w = (PPN_W > 0);
endmodule

// File: rtl/ptw_chk.sv
// Module: property checker for the page table walker, attached by bind.
// Assumes only the top-level ports are observed.
module ptw_chk #(
    parameter int PA_W  = 32,
    parameter int PTE_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            walk_valid,
    input logic            walk_ready,
    input logic            rd_valid,
    input logic            rd_ready,
    input logic [PA_W-1:0] rd_addr,
    input logic            res_valid,
    input logic            res_fault,
    input logic            res_deny
);
    // R9
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));

    // R8
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_valid && walk_ready) |=> !walk_ready);

    // R8
    no_ready_while_reading_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !walk_ready);

    // R6
    result_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    // R7
    no_deny_on_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_fault) |-> !res_deny);

    // R6
    result_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (!walk_ready && !rd_valid));
endmodule

bind pt_walker ptw_chk #(
    .PA_W  (PA_W),
    .PTE_W (PTE_W)
) u_ptw_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .walk_valid (walk_valid),
    .walk_ready (walk_ready),
    .rd_valid   (rd_valid),
    .rd_ready   (rd_ready),
    .rd_addr    (rd_addr),
    .res_valid  (res_valid),
    .res_fault  (res_fault),
    .res_deny   (res_deny)
);

// File: tb/tb_pt_walker.sv
// Bench: table-driven walks followed by directed reset, stall and busy tests.
module tb_pt_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        walk_valid = 1'b0;
    logic        walk_ready;
    logic [31:0] walk_va = '0;
    logic [1:0]  walk_acc = '0;
    logic [31:0] walk_root = '0;
    logic        rd_valid;
    logic        rd_ready;
    logic [31:0] rd_addr;
    logic        rsp_valid;
    logic [31:0] rsp_data;
    logic        res_valid, res_fault, res_level, res_deny;
    logic [31:0] res_pte;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    pt_walker dut (
        .clk(clk), .rst_n(rst_n),
        .walk_valid(walk_valid), .walk_ready(walk_ready),
        .walk_va(walk_va), .walk_acc(walk_acc), .walk_root(walk_root),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .res_valid(res_valid), .res_fault(res_fault), .res_level(res_level),
        .res_pte(res_pte), .res_deny(res_deny)
    );

    // Memory model: sparse image, programmable latency and stall pattern.
    logic [31:0] mem_img [logic [31:0]];
    logic [31:0] rd_log [64];
    int          n_reads = 0;
    int          lat = 0;
    bit          stall_en = 1'b0;
    logic [1:0]  stall_cnt = '0;
    bit          pend = 1'b0;
    int          pend_cnt = 0;
    logic [31:0] pend_data = '0;
    logic        rsp_v_q = 1'b0;
    logic [31:0] rsp_d_q = '0;

    assign rd_ready  = stall_en ? (stall_cnt == 2'd3) : 1'b1;
    assign rsp_valid = rsp_v_q;
    assign rsp_data  = rsp_d_q;

    function automatic logic [31:0] peek(input logic [31:0] a);
        return mem_img.exists(a) ? mem_img[a] : 32'h0;
    endfunction

    always @(posedge clk) begin
        stall_cnt <= stall_cnt + 2'd1;
        rsp_v_q   <= 1'b0;
        if (!rst_n) begin
            pend <= 1'b0;
        end else if (pend) begin
            if (pend_cnt == 0) begin
                rsp_v_q <= 1'b1;
                rsp_d_q <= pend_data;
                pend    <= 1'b0;
            end else begin
                pend_cnt <= pend_cnt - 1;
            end
        end else if (rd_valid && rd_ready) begin
            pend      <= 1'b1;
            pend_cnt  <= lat;
            pend_data <= peek(rd_addr);
            rd_log[n_reads % 64] <= rd_addr;
            n_reads   <= n_reads + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Reference model, built only from the requirement text.
    typedef struct {
        bit          fault;
        bit          level;
        logic [31:0] pte;
        bit          deny;
        int          reads;
        logic [31:0] a1;
        logic [31:0] a2;
    } exp_t;

    function automatic exp_t model(input logic [31:0] va, input logic [1:0] acc,
                                   input logic [31:0] root);
        exp_t e;
        logic [31:0] p1, p2;
        e.a1 = root + {20'h0, va[31:22], 2'b00};
        p1 = peek(e.a1);
        e.a2 = {p1[31:12], 12'h000} + {20'h0, va[21:12], 2'b00};
        e.deny = 1'b0;
        if (!p1[0]) begin
            e.fault = 1'b1; e.level = 1'b0; e.pte = p1; e.reads = 1;
        end else begin
            p2 = peek(e.a2);
            e.fault = !p2[0]; e.level = 1'b1; e.pte = p2; e.reads = 2;
            if (p2[0])
                e.deny = (acc == 2'd3) || (acc == 2'd0 && !p2[1]) ||
                         (acc == 2'd1 && !p2[2]) || (acc == 2'd2 && !p2[3]);
        end
        return e;
    endfunction

    task automatic launch(input logic [31:0] va, input logic [1:0] acc, input logic [31:0] root);
        @(negedge clk);
        walk_va = va; walk_acc = acc; walk_root = root; walk_valid = 1'b1;
        @(negedge clk);
        walk_valid = 1'b0;
    endtask

    task automatic wait_result(output bit got);
        got = 1'b0;
        for (int i = 0; i < 400; i++) begin
            if (res_valid) begin got = 1'b1; break; end
            @(negedge clk);
        end
    endtask

    task automatic check_walk(input string tag, input exp_t e, input int r0);
        bit got;
        wait_result(got);
        chk(got, tag, "result strobe seen", 32'(got), 32'd1);
        if (got) begin
            chk(res_fault == e.fault, e.fault ? (e.level ? "R5" : "R4") : "R6",
                {tag, " fault"}, 32'(res_fault), 32'(e.fault));
            chk(res_level == e.level, e.fault ? (e.level ? "R5" : "R4") : "R6",
                {tag, " level"}, 32'(res_level), 32'(e.level));
            chk(res_pte == e.pte, "R6", {tag, " entry"}, res_pte, e.pte);
            chk(res_deny == e.deny, "R7", {tag, " deny"}, 32'(res_deny), 32'(e.deny));
            chk((n_reads - r0) == e.reads, e.reads == 1 ? "R4" : "R3",
                {tag, " read count"}, 32'(n_reads - r0), 32'(e.reads));
            chk(rd_log[r0 % 64] == e.a1, "R2", {tag, " first read addr"}, rd_log[r0 % 64], e.a1);
            if (e.reads == 2)
                chk(rd_log[(r0 + 1) % 64] == e.a2, "R3", {tag, " second read addr"},
                    rd_log[(r0 + 1) % 64], e.a2);
            @(negedge clk);
            chk(!res_valid, "R6", {tag, " strobe one cycle"}, 32'(res_valid), 32'd0);
            chk(walk_ready, "R8", {tag, " ready after walk"}, 32'(walk_ready), 32'd1);
        end
    endtask

    typedef struct packed {
        logic [31:0] va;
        logic [1:0]  acc;
        logic [31:0] root;
        logic [31:0] l1;
        logic [31:0] l2;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{va: 32'h0040_3123, acc: 2'd0, root: 32'h0001_0000, l1: 32'h0002_0001, l2: 32'h0ABC_D003},
        '{va: 32'h0040_3FFF, acc: 2'd1, root: 32'h0001_0000, l1: 32'h0002_0001, l2: 32'h0ABC_D003},
        '{va: 32'hFFFF_FFFF, acc: 2'd2, root: 32'h0008_0000, l1: 32'h1234_5001, l2: 32'h0005_5009},
        '{va: 32'h1234_5678, acc: 2'd0, root: 32'h0004_0000, l1: 32'h0003_0000, l2: 32'h0000_0003},
        '{va: 32'h8000_1000, acc: 2'd0, root: 32'h0006_0000, l1: 32'h0007_0001, l2: 32'h0777_700E},
        '{va: 32'h0000_0000, acc: 2'd1, root: 32'hFFFF_F000, l1: 32'h0000_0001, l2: 32'hFFFF_F005},
        '{va: 32'h00C0_2ABC, acc: 2'd3, root: 32'h0010_0000, l1: 32'h0020_0001, l2: 32'h0000_100F}
    };

    task automatic load_vec(input vec_t v);
        logic [31:0] a1;
        mem_img.delete();
        a1 = v.root + {20'h0, v.va[31:22], 2'b00};
        mem_img[a1] = v.l1;
        mem_img[{v.l1[31:12], 12'h000} + {20'h0, v.va[21:12], 2'b00}] = v.l2;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual expired expected finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : main
        exp_t e;
        int r0;
        bit got;
        repeat (3) @(negedge clk);
        // R1: reset values
        chk(walk_ready == 1'b1, "R1", "ready in reset", 32'(walk_ready), 32'd1);
        chk(rd_valid == 1'b0, "R1", "no read in reset", 32'(rd_valid), 32'd0);
        chk(res_valid == 1'b0, "R1", "no result in reset", 32'(res_valid), 32'd0);
        rst_n = 1'b1;

        // Table of walks: success, denied store, fetch at top index, faults, reserved kind.
        for (int i = 0; i < NV; i++) begin
            load_vec(VECS[i]);
            lat = i % 3;
            e = model(VECS[i].va, VECS[i].acc, VECS[i].root);
            r0 = n_reads;
            launch(VECS[i].va, VECS[i].acc, VECS[i].root);
            check_walk($sformatf("vec%0d", i), e, r0);
        end

        // R2: root changed after acceptance does not steer the walk.
        load_vec(VECS[0]);
        lat = 4;
        e = model(VECS[0].va, VECS[0].acc, VECS[0].root);
        r0 = n_reads;
        launch(VECS[0].va, VECS[0].acc, VECS[0].root);
        walk_root = 32'h00AB_0000;
        check_walk("R2 root latched", e, r0);

        // R3: page offset bits do not change read addresses.
        load_vec(VECS[0]);
        lat = 0;
        e = model(32'h0040_3000, 2'd0, VECS[0].root);
        r0 = n_reads;
        launch(32'h0040_3FFC, 2'd0, VECS[0].root);
        check_walk("R3 offset ignored", e, r0);

        // R9: stalled read port and long latency.
        stall_en = 1'b1;
        lat = 6;
        load_vec(VECS[2]);
        e = model(VECS[2].va, VECS[2].acc, VECS[2].root);
        r0 = n_reads;
        launch(VECS[2].va, VECS[2].acc, VECS[2].root);
        check_walk("R9 stalled port", e, r0);
        stall_en = 1'b0;

        // R8: a request raised while busy starts nothing.
        load_vec(VECS[0]);
        lat = 3;
        e = model(VECS[0].va, VECS[0].acc, VECS[0].root);
        r0 = n_reads;
        launch(VECS[0].va, VECS[0].acc, VECS[0].root);
        @(negedge clk);
        chk(!walk_ready, "R8", "ready low while busy", 32'(walk_ready), 32'd0);
        walk_va = 32'hFFC0_0000; walk_root = 32'h0090_0000; walk_valid = 1'b1;
        @(negedge clk);
        walk_valid = 1'b0;
        check_walk("R8 busy request", e, r0);
        repeat (20) @(negedge clk);
        chk(n_reads - r0 == 2, "R8", "no reads from busy request", 32'(n_reads - r0), 32'd2);
        wait_result(got);
        got = res_valid;
        chk(!got, "R8", "no extra result", 32'(got), 32'd0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule